// File: doc/BRIEF.md
# Flash Hardware Sequencer Controller

This block lets a host run a fixed set of serial flash operations through a few memory-mapped registers instead of shifting bytes itself. The host places a target address in the address register, fills the 64-byte data buffer when it is sending data, then writes the control/status register with a cycle code, a byte count and the go bit. The block builds the command frames, hands them byte by byte to a serial master over a request/acknowledge handshake, stores any returned data in the buffer and raises a completion flag.

Program and erase operations are wrapped automatically. A separate write-enable frame is sent first. Afterwards the flash status register is polled until its busy bit reads zero. Requests that are malformed or that target an address the external protection logic refuses are rejected before any byte reaches the flash. The two erase command bytes come from a configuration register, and a sticky lock bit freezes that register until reset.

Top module: `flashSeqCtrl`

## Requirements
- R1: After reset the control/status register (offset 0x04) reads 0, the erase configuration register (offset 0x0C) reads 0x00D82000, the data buffer reads 0 and `spiReq` is low.
- R2: A write to offset 0x04 with bit 16 set starts a cycle only when no cycle is running. Bit 5 reads 1 from the next clock until completion, and bit 0 (done) is set when the cycle ends. A go write that arrives during a cycle is ignored and leaves the cycle field unchanged.
- R3: The cycle field sits at bits 20:17. Each code sends the following frame:
  - 0 (read): byte 0x03, then three address bytes with the most significant byte first, then the data bytes.
  - 6 (identify): byte 0x9F, then the data bytes.
  - 8 (status read): byte 0x05, then the data bytes.
  - 2 (program): byte 0x02, then the address bytes, then the data bytes.
  - 7 (status write): byte 0x01, then the data bytes.
- R4: Bits 29:24 hold the byte count minus one, so a single cycle moves between 1 and 64 data bytes.
- R5: Codes 2, 3, 4 and 7 are preceded by a one-byte 0x06 frame. They are followed by 0x05 poll frames of two bytes each, repeated until bit 0 of the returned status byte is 0. Done is set only after the last poll.
- R6: The buffer occupies offsets 0x10 to 0x4C. Data byte k lives in word k/4 at bits 8*(k%4)+7:8*(k%4). Received bytes are written there, and transmitted bytes are taken from there.
- R7: Code 3 sends the byte held in configuration bits 15:8, and code 4 sends the byte held in bits 23:16, each followed by the three address bytes. If the selected byte is zero, the cycle ends with bit 1 (error) and done set and no serial byte sent.
- R8: A read or program cycle whose address offset within a 4 KiB page plus its byte count exceeds 4096 ends with error and done set and no serial byte sent. An undefined cycle code (1, 5, 9 to 15) is handled the same way.
- R9: For the address-carrying codes 0, 2, 3 and 4, an asserted `protDeny` ends the cycle with bit 2 (access violation) and done set and no serial byte sent. Codes 6, 7 and 8 ignore `protDeny`.
- R10: Bits 0, 1 and 2 are cleared by writing 1 to them, including in the same write that sets go. Writing 0 leaves them unchanged.
- R11: Writing 1 to bit 15 sets the lock. The lock then reads 1 until reset, and while it is set, writes to offset 0x0C are ignored.
- R12: `spiReq` stays high and `spiTxByte` stays stable until `spiAck` is pulsed. `spiFrameEnd` is high only on the last byte of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 7 | Register byte offset for reads and writes |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| protAddr | output | 24 | Flash address presented to the protection logic |
| protDeny | input | 1 | Protection logic refuses access to `protAddr` |
| spiReq | output | 1 | A byte is offered to the serial master |
| spiTxByte | output | 8 | Byte to shift out |
| spiFrameEnd | output | 1 | Release chip select after this byte |
| spiAck | input | 1 | One-cycle pulse: the offered byte has been shifted |
| spiRxByte | input | 8 | Byte shifted in, valid with `spiAck` |

## Verification
The bench targets the page-boundary check at its exact edge. A 64-byte read that ends on the last byte of a page must run, while a read one byte later must be refused. An off-by-one comparison either drops a legal transfer or leaks a request across the page. The bench also checks:
- Polling with a flash that reports busy several times, so that a controller which stops after one poll shows too few bytes and an early done.
- A go write issued mid-cycle, which a careless design would restart or use to corrupt the running cycle's code.
- Erase-code selection, the zero-code rejection and the lock against later configuration writes, so that a swapped byte field or a lock that can be cleared shows up as a wrong opcode on the wire.

// File: rtl/hwseqPkg.sv
package hwseqPkg;

  localparam int BUF_IDX_W = 6;

  localparam logic [3:0] CYC_READ    = 4'd0;
  localparam logic [3:0] CYC_PROG    = 4'd2;
  localparam logic [3:0] CYC_ERASE   = 4'd3;
  localparam logic [3:0] CYC_ERASE64 = 4'd4;
  localparam logic [3:0] CYC_IDENT   = 4'd6;
  localparam logic [3:0] CYC_WRSTAT  = 4'd7;
  localparam logic [3:0] CYC_RDSTAT  = 4'd8;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_IDENT  = 8'h9F;
  localparam logic [7:0] OP_WRSTAT = 8'h01;
  localparam logic [7:0] OP_RDSTAT = 8'h05;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_WREN, ST_OPC, ST_ADDR, ST_DATA, ST_PCMD, ST_PRD, ST_FIN
  } seqStateT;

  typedef struct packed {
    logic                 bufWr;
    logic [BUF_IDX_W-1:0] bufIdx;
    logic [7:0]           bufByte;
    logic                 setErr;
    logic                 setAel;
    logic                 setDone;
  } seqStrobeT;

endpackage

// File: rtl/hwseqDatapath.sv
module hwseqDatapath
  import hwseqPkg::*;
#(
  parameter int         ADDR_W    = 24,
  parameter int         BUF_BYTES = 64,
  parameter int         REG_AW    = 7,
  parameter logic [7:0] E4_RST    = 8'h20,
  parameter logic [7:0] E64_RST   = 8'hD8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 busyIn,
  input  seqStrobeT            strobe,
  input  logic [BUF_IDX_W-1:0] bufRdIdx,
  output logic [7:0]           bufRdByte,
  output logic                 goPulse,
  output logic [3:0]           cycleCode,
  output logic [BUF_IDX_W-1:0] byteCount,
  output logic [ADDR_W-1:0]    flashAddr,
  output logic [7:0]           erase4Op,
  output logic [7:0]           erase64Op
);

  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int WIDX_W    = $clog2(BUF_WORDS);
  localparam int OFF_STAT  = 4;
  localparam int OFF_ADDR  = 8;
  localparam int OFF_CFG   = 12;
  localparam int OFF_BUF   = 16;

  logic [7:0] bufMem [BUF_BYTES];
  logic       doneFlag, errFlag, aelFlag, lockFlag;
  logic       statWr, addrWr, cfgWr, isBuf, bufWordWr;
  logic [WIDX_W-1:0] wordIdx;

  assign statWr    = regWrEn && (regAddr == REG_AW'(OFF_STAT));
  assign addrWr    = regWrEn && (regAddr == REG_AW'(OFF_ADDR)) && !busyIn;
  assign cfgWr     = regWrEn && (regAddr == REG_AW'(OFF_CFG)) && !lockFlag;
  assign isBuf     = (regAddr >= REG_AW'(OFF_BUF)) && (regAddr < REG_AW'(OFF_BUF + BUF_BYTES));
  assign wordIdx   = WIDX_W'((regAddr - REG_AW'(OFF_BUF)) >> 2);
  assign bufWordWr = regWrEn && isBuf;
  assign goPulse   = statWr && regWdata[16] && !busyIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCode <= '0;
      byteCount <= '0;
      flashAddr <= '0;
      erase4Op  <= E4_RST;
      erase64Op <= E64_RST;
      doneFlag  <= 1'b0;
      errFlag   <= 1'b0;
      aelFlag   <= 1'b0;
      lockFlag  <= 1'b0;
    end else begin
      if (statWr && !busyIn) begin
        cycleCode <= regWdata[20:17];
        byteCount <= regWdata[24 +: BUF_IDX_W];
      end
      if (addrWr) flashAddr <= regWdata[ADDR_W-1:0];
      if (cfgWr) begin
        erase4Op  <= regWdata[15:8];
        erase64Op <= regWdata[23:16];
      end
      doneFlag <= (doneFlag && !(statWr && regWdata[0])) || strobe.setDone;
      errFlag  <= (errFlag  && !(statWr && regWdata[1])) || strobe.setErr;
      aelFlag  <= (aelFlag  && !(statWr && regWdata[2])) || strobe.setAel;
      lockFlag <= lockFlag || (statWr && regWdata[15]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BUF_BYTES; b++) bufMem[b] <= '0;
    end else begin
      for (int b = 0; b < BUF_BYTES; b++) begin
        if (strobe.bufWr && strobe.bufIdx == BUF_IDX_W'(b))
          bufMem[b] <= strobe.bufByte;
        else if (bufWordWr && wordIdx == WIDX_W'(b / 4))
          bufMem[b] <= regWdata[8*(b%4) +: 8];
      end
    end
  end

  assign bufRdByte = bufMem[bufRdIdx];

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_AW'(OFF_STAT)) begin
      regRdata[24 +: BUF_IDX_W] = byteCount;
      regRdata[20:17]           = cycleCode;
      regRdata[15]              = lockFlag;
      regRdata[5]               = busyIn;
      regRdata[2:0]             = {aelFlag, errFlag, doneFlag};
    end else if (regAddr == REG_AW'(OFF_ADDR)) begin
      regRdata[ADDR_W-1:0] = flashAddr;
    end else if (regAddr == REG_AW'(OFF_CFG)) begin
      regRdata[23:16] = erase64Op;
      regRdata[15:8]  = erase4Op;
    end else if (isBuf) begin
      for (int k = 0; k < 4; k++)
        regRdata[8*k +: 8] = bufMem[{wordIdx, 2'(k)}];
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |=> lockFlag); // R11
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |=> ($stable(erase4Op) && $stable(erase64Op))); // R11
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !busyIn); // R2
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && $past(busyIn)) |-> $stable(cycleCode)); // R2

endmodule

// File: rtl/hwseqControl.sv
module hwseqControl
  import hwseqPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 goPulse,
  input  logic [3:0]           cycleCode,
  input  logic [BUF_IDX_W-1:0] byteCount,
  input  logic [ADDR_W-1:0]    flashAddr,
  input  logic [7:0]           erase4Op,
  input  logic [7:0]           erase64Op,
  input  logic                 protDeny,
  input  logic [7:0]           bufRdByte,
  output logic [BUF_IDX_W-1:0] bufRdIdx,
  output seqStrobeT            strobe,
  output logic                 busy,
  output logic                 spiReq,
  output logic [7:0]           spiTxByte,
  output logic                 spiFrameEnd,
  input  logic                 spiAck,
  input  logic [7:0]           spiRxByte
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AIDX_W     = $clog2(ADDR_BYTES);
  localparam int PAGE_W     = $clog2(PAGE_BYTES);

  seqStateT state, stNext;
  logic [AIDX_W-1:0]    addrIdx, aIdxNext;
  logic [BUF_IDX_W-1:0] dataIdx, dIdxNext;

  logic       isValid, usesAddr, hasData, needsWren, writeDir;
  logic       crosses, zeroErase, reject, deny, lastAddr, lastData;
  logic [7:0] opcode, addrByte;
  logic [PAGE_W:0] span;

  always_comb begin
    isValid = 1'b1; usesAddr = 1'b0; hasData = 1'b1; needsWren = 1'b0;
    writeDir = 1'b0; opcode = OP_READ;
    case (cycleCode)
      CYC_READ:    begin usesAddr = 1'b1; opcode = OP_READ; end
      CYC_PROG:    begin usesAddr = 1'b1; needsWren = 1'b1; writeDir = 1'b1; opcode = OP_PROG; end
      CYC_ERASE:   begin usesAddr = 1'b1; needsWren = 1'b1; hasData = 1'b0; opcode = erase4Op; end
      CYC_ERASE64: begin usesAddr = 1'b1; needsWren = 1'b1; hasData = 1'b0; opcode = erase64Op; end
      CYC_IDENT:   opcode = OP_IDENT;
      CYC_WRSTAT:  begin needsWren = 1'b1; writeDir = 1'b1; opcode = OP_WRSTAT; end
      CYC_RDSTAT:  opcode = OP_RDSTAT;
      default:     isValid = 1'b0;
    endcase
  end

  assign span      = {1'b0, flashAddr[PAGE_W-1:0]} + (PAGE_W+1)'(byteCount) + (PAGE_W+1)'(1);
  assign crosses   = (cycleCode == CYC_READ || cycleCode == CYC_PROG) &&
                     (span > (PAGE_W+1)'(PAGE_BYTES));
  assign zeroErase = (cycleCode == CYC_ERASE && erase4Op == 8'h00) ||
                     (cycleCode == CYC_ERASE64 && erase64Op == 8'h00);
  assign reject    = !isValid || crosses || zeroErase;
  assign deny      = usesAddr && protDeny;
  assign lastAddr  = (addrIdx == AIDX_W'(ADDR_BYTES - 1));
  assign lastData  = (dataIdx == byteCount);
  assign addrByte  = 8'(flashAddr >> (8 * (ADDR_BYTES - 1 - int'(addrIdx))));
  assign bufRdIdx  = dataIdx;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    stNext = state; aIdxNext = addrIdx; dIdxNext = dataIdx;
    strobe = '0; spiReq = 1'b0; spiTxByte = 8'h00; spiFrameEnd = 1'b0;
    case (state)
      ST_IDLE: if (goPulse) stNext = ST_CHECK;
      ST_CHECK: begin
        aIdxNext = '0;
        dIdxNext = '0;
        if (reject) begin
          strobe.setErr = 1'b1; stNext = ST_FIN;
        end else if (deny) begin
          strobe.setAel = 1'b1; stNext = ST_FIN;
        end else begin
          stNext = needsWren ? ST_WREN : ST_OPC;
        end
      end
      ST_WREN: begin
        spiReq = 1'b1; spiTxByte = OP_WREN; spiFrameEnd = 1'b1;
        if (spiAck) stNext = ST_OPC;
      end
      ST_OPC: begin
        spiReq = 1'b1; spiTxByte = opcode;
        if (spiAck) stNext = usesAddr ? ST_ADDR : ST_DATA;
      end
      ST_ADDR: begin
        spiReq = 1'b1; spiTxByte = addrByte; spiFrameEnd = lastAddr && !hasData;
        if (spiAck) begin
          if (!lastAddr) aIdxNext = addrIdx + 1'b1;
          else if (hasData) stNext = ST_DATA;
          else stNext = needsWren ? ST_PCMD : ST_FIN;
        end
      end
      ST_DATA: begin
        spiReq = 1'b1; spiTxByte = writeDir ? bufRdByte : 8'h00; spiFrameEnd = lastData;
        if (spiAck) begin
          if (!writeDir) begin
            strobe.bufWr = 1'b1; strobe.bufIdx = dataIdx; strobe.bufByte = spiRxByte;
          end
          if (lastData) stNext = needsWren ? ST_PCMD : ST_FIN;
          else dIdxNext = dataIdx + 1'b1;
        end
      end
      ST_PCMD: begin
        spiReq = 1'b1; spiTxByte = OP_RDSTAT;
        if (spiAck) stNext = ST_PRD;
      end
      ST_PRD: begin
        spiReq = 1'b1; spiFrameEnd = 1'b1;
        if (spiAck) stNext = spiRxByte[0] ? ST_PCMD : ST_FIN;
      end
      ST_FIN: begin
        strobe.setDone = 1'b1; stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      addrIdx <= '0;
      dataIdx <= '0;
    end else begin
      state   <= stNext;
      addrIdx <= aIdxNext;
      dataIdx <= dIdxNext;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck) |=> spiReq); // R12
  AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck) |=> $stable(spiTxByte)); // R12
  AST_NO_SPI_ON_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && (reject || deny)) |=> !spiReq); // R8
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setErr && strobe.setAel)); // R9

endmodule

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import hwseqPkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         BUF_BYTES  = 64,
  parameter int         PAGE_BYTES = 4096,
  parameter int         REG_AW     = 7,
  parameter logic [7:0] E4_RST     = 8'h20,
  parameter logic [7:0] E64_RST    = 8'hD8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [ADDR_W-1:0] protAddr,
  input  logic              protDeny,
  output logic              spiReq,
  output logic [7:0]        spiTxByte,
  output logic              spiFrameEnd,
  input  logic              spiAck,
  input  logic [7:0]        spiRxByte
);

  seqStrobeT            strobe;
  logic                 busy, goPulse;
  logic [3:0]           cycleCode;
  logic [BUF_IDX_W-1:0] byteCount, bufRdIdx;
  logic [ADDR_W-1:0]    flashAddr;
  logic [7:0]           erase4Op, erase64Op, bufRdByte;

  assign protAddr = flashAddr;

  hwseqDatapath #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .REG_AW(REG_AW),
    .E4_RST(E4_RST), .E64_RST(E64_RST)
  ) uData (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busyIn(busy), .strobe(strobe),
    .bufRdIdx(bufRdIdx), .bufRdByte(bufRdByte), .goPulse(goPulse),
    .cycleCode(cycleCode), .byteCount(byteCount), .flashAddr(flashAddr),
    .erase4Op(erase4Op), .erase64Op(erase64Op)
  );

  hwseqControl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .goPulse(goPulse), .cycleCode(cycleCode),
    .byteCount(byteCount), .flashAddr(flashAddr), .erase4Op(erase4Op),
    .erase64Op(erase64Op), .protDeny(protDeny), .bufRdByte(bufRdByte),
    .bufRdIdx(bufRdIdx), .strobe(strobe), .busy(busy), .spiReq(spiReq),
    .spiTxByte(spiTxByte), .spiFrameEnd(spiFrameEnd), .spiAck(spiAck),
    .spiRxByte(spiRxByte)
  );

endmodule

// File: tb/tb_flashSeqCtrl.sv
`timescale 1ns/1ps
module tb_flashSeqCtrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [23:0] protAddr;
  logic        protDeny = 1'b0;
  logic        spiReq, spiFrameEnd;
  logic [7:0]  spiTxByte;
  logic        spiAck = 1'b0;
  logic [7:0]  spiRxByte = '0;

  always #2.5 clk = ~clk;

  flashSeqCtrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .protAddr(protAddr),
    .protDeny(protDeny), .spiReq(spiReq), .spiTxByte(spiTxByte),
    .spiFrameEnd(spiFrameEnd), .spiAck(spiAck), .spiRxByte(spiRxByte)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] sentByte [256];
  logic       sentEnd  [256];
  int         sentCount = 0;
  int         pollLeft = 0;
  logic [7:0] statusVal = 8'h00;
  logic [31:0] s;

  // vector: cycle, count-1, address, deny, expErr, expAel, expected bytes
  localparam int NV = 15;
  localparam logic [44:0] VEC [NV] = '{
    {4'd0, 6'd3,  24'h000100, 1'b0, 1'b0, 1'b0, 8'd8},   // R3 read
    {4'd0, 6'd63, 24'h000FC0, 1'b0, 1'b0, 1'b0, 8'd68},  // R4 R8 ends on page edge
    {4'd0, 6'd63, 24'h000FC1, 1'b0, 1'b1, 1'b0, 8'd0},   // R8 crosses page
    {4'd2, 6'd1,  24'h002000, 1'b0, 1'b0, 1'b0, 8'd9},   // R5 program
    {4'd3, 6'd0,  24'h003000, 1'b0, 1'b0, 1'b0, 8'd7},   // R7 erase
    {4'd4, 6'd0,  24'h010000, 1'b0, 1'b0, 1'b0, 8'd7},   // R7 erase 64K
    {4'd1, 6'd0,  24'h000000, 1'b0, 1'b1, 1'b0, 8'd0},   // R8 undefined
    {4'd6, 6'd2,  24'h000000, 1'b0, 1'b0, 1'b0, 8'd4},   // R3 identify
    {4'd7, 6'd0,  24'h000000, 1'b0, 1'b0, 1'b0, 8'd5},   // R5 status write
    {4'd8, 6'd0,  24'h000000, 1'b0, 1'b0, 1'b0, 8'd2},   // R3 status read
    {4'd0, 6'd0,  24'h000200, 1'b1, 1'b0, 1'b1, 8'd0},   // R9 read denied
    {4'd3, 6'd0,  24'h005000, 1'b1, 1'b0, 1'b1, 8'd0},   // R9 erase denied
    {4'd9, 6'd0,  24'h000000, 1'b0, 1'b1, 1'b0, 8'd0},   // R8 undefined
    {4'd6, 6'd0,  24'h000000, 1'b1, 1'b0, 1'b0, 8'd2},   // R9 deny ignored
    {4'd2, 6'd0,  24'h000FFF, 1'b0, 1'b0, 1'b0, 8'd8}    // R8 last byte of page
  };

  // serial master and flash model
  initial begin
    int waitCnt = 0;
    int frameIdx = 0;
    logic [7:0] curOp = 8'h00;
    forever begin
      @(negedge clk);
      if (spiAck) begin
        spiAck = 1'b0;
      end else if (spiReq) begin
        waitCnt++;
        if (waitCnt == 2) begin
          waitCnt = 0;
          if (frameIdx == 0) curOp = spiTxByte;
          if (sentCount < 256) begin
            sentByte[sentCount] = spiTxByte;
            sentEnd[sentCount]  = spiFrameEnd;
          end
          sentCount++;
          if (curOp == 8'h05 && frameIdx > 0) begin
            if (pollLeft > 0) begin spiRxByte = 8'h01; pollLeft--; end
            else spiRxByte = statusVal;
          end else begin
            spiRxByte = 8'(8'h30 + frameIdx);
          end
          frameIdx = spiFrameEnd ? 0 : frameIdx + 1;
          spiAck = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] st;
    for (int i = 0; i < 3000; i++) begin
      regRead(7'h04, st);
      if (!st[5]) return;
    end
    chk(1'b0, "R2 cycle never completed", st, 32'h0);
  endtask

  task automatic startCycle(input logic [3:0] cyc, input logic [5:0] cnt);
    regWrite(7'h04, {2'b0, cnt, 3'b0, cyc, 1'b1, 16'h0007});
  endtask

  task automatic runCycle(input logic [3:0] cyc, input logic [5:0] cnt,
                          input logic [23:0] adr, input logic deny);
    protDeny = deny;
    regWrite(7'h08, {8'h0, adr});
    sentCount = 0;
    startCycle(cyc, cnt);
    waitIdle();
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] expW [12];
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(7'h04, s); chk(s == 32'h0, "R1 status after reset", s, 32'h0);
    regRead(7'h0C, s); chk(s == 32'h00D82000, "R1 erase config after reset", s, 32'h00D82000);
    regRead(7'h10, s); chk(s == 32'h0, "R1 buffer after reset", s, 32'h0);
    chk(spiReq == 1'b0, "R1 spiReq after reset", 32'(spiReq), 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      runCycle(v[44:41], v[40:35], v[34:11], v[10]);
      regRead(7'h04, s);
      chk(s[0] == 1'b1, $sformatf("R2 done vec %0d", i), 32'(s[0]), 32'h1);
      chk(s[1] == v[9], $sformatf("R8 error flag vec %0d", i), 32'(s[1]), 32'(v[9]));
      chk(s[2] == v[8], $sformatf("R9 access flag vec %0d", i), 32'(s[2]), 32'(v[8]));
      chk(sentCount == int'(v[7:0]), $sformatf("R3 R5 byte count vec %0d", i), sentCount, 32'(v[7:0]));
    end
    protDeny = 1'b0;

    // R6 read data placement, R3 frame bytes, R12 frame end
    runCycle(4'd0, 6'd3, 24'h000100, 1'b0);
    regRead(7'h10, s); chk(s == 32'h37363534, "R6 read data little-endian", s, 32'h37363534);
    expW[0] = 8'h03; expW[1] = 8'h00; expW[2] = 8'h01; expW[3] = 8'h00;
    for (int k = 0; k < 4; k++)
      chk(sentByte[k] == expW[k], $sformatf("R3 read frame byte %0d", k), sentByte[k], expW[k]);
    chk(sentEnd[7] == 1'b1 && sentEnd[3] == 1'b0, "R12 frame end only on last byte",
        {sentEnd[3], sentEnd[7]}, 32'h1);

    // R5 R6 program frames
    regWrite(7'h10, 32'h44332211);
    regWrite(7'h14, 32'h88776655);
    runCycle(4'd2, 6'd4, 24'h002000, 1'b0);
    chk(sentCount == 12, "R5 program total bytes", sentCount, 12);
    expW = '{8'h06, 8'h02, 8'h00, 8'h20, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h05, 8'h00};
    for (int k = 0; k < 12; k++)
      chk(sentByte[k] == expW[k], $sformatf("R6 program byte %0d", k), sentByte[k], expW[k]);
    chk(sentEnd[0] && sentEnd[9] && sentEnd[11] && !sentEnd[8], "R5 separate frames",
        {sentEnd[0], sentEnd[8], sentEnd[9], sentEnd[11]}, 32'hB);

    // R5 polling repeats while flash busy
    pollLeft = 3;
    runCycle(4'd3, 6'd0, 24'h003000, 1'b0);
    chk(sentCount == 13, "R5 poll until ready", sentCount, 13);

    // R3 status read data lands in buffer
    statusVal = 8'h5C;
    runCycle(4'd8, 6'd0, 24'h0, 1'b0);
    statusVal = 8'h00;
    regRead(7'h10, s); chk(s[7:0] == 8'h5C, "R3 status read byte", s[7:0], 8'h5C);

    // R2 go while busy ignored
    pollLeft = 5;
    regWrite(7'h08, 24'h006000);
    sentCount = 0;
    startCycle(4'd3, 6'd0);
    regRead(7'h04, s); chk(s[5] == 1'b1, "R2 busy during cycle", 32'(s[5]), 32'h1);
    startCycle(4'd0, 6'd0);
    waitIdle();
    repeat (20) @(negedge clk);
    chk(sentCount == 17, "R2 second go ignored", sentCount, 17);
    regRead(7'h04, s); chk(s[20:17] == 4'd3, "R2 cycle field kept", s[20:17], 4'd3);

    // R10 write-one-to-clear
    regWrite(7'h04, 32'h0);
    regRead(7'h04, s); chk(s[0] == 1'b1, "R10 zero write keeps done", 32'(s[0]), 32'h1);
    regWrite(7'h04, 32'h1);
    regRead(7'h04, s); chk(s[0] == 1'b0, "R10 done cleared", 32'(s[0]), 32'h0);
    runCycle(4'd5, 6'd0, 24'h0, 1'b0);
    regWrite(7'h04, 32'h2);
    regRead(7'h04, s); chk(s[2:0] == 3'b001, "R10 error cleared alone", s[2:0], 3'b001);

    // R7 erase opcode selection and zero code
    regWrite(7'h0C, 32'h00528100);
    runCycle(4'd3, 6'd0, 24'h004000, 1'b0);
    chk(sentByte[1] == 8'h81, "R7 4K erase opcode", sentByte[1], 8'h81);
    runCycle(4'd4, 6'd0, 24'h020000, 1'b0);
    chk(sentByte[1] == 8'h52, "R7 64K erase opcode", sentByte[1], 8'h52);
    regWrite(7'h0C, 32'h00520000);
    runCycle(4'd3, 6'd0, 24'h004000, 1'b0);
    regRead(7'h04, s);
    chk(s[1:0] == 2'b11 && sentCount == 0, "R7 zero erase code rejected", {s[1:0], 8'(sentCount)}, 32'h300);

    // R11 lock
    regWrite(7'h0C, 32'h00D82000);
    regWrite(7'h04, 32'h00008000);
    regRead(7'h04, s); chk(s[15] == 1'b1, "R11 lock set", 32'(s[15]), 32'h1);
    regWrite(7'h0C, 32'h0);
    regRead(7'h0C, s); chk(s == 32'h00D82000, "R11 config frozen", s, 32'h00D82000);
    runCycle(4'd3, 6'd0, 24'h007000, 1'b0);
    chk(sentByte[1] == 8'h20, "R11 locked erase code used", sentByte[1], 8'h20);
    regRead(7'h04, s); chk(s[15] == 1'b1, "R11 lock sticky", 32'(s[15]), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule